// File: doc/BRIEF.md
# Twin-Bus Register Datapath

This block is the execution half of a microcoded processor: a bank of word-wide registers, a source bus (the B bus) that carries one selected register to the right-hand ALU input, and a holding register H that feeds the left-hand input. The ALU result goes through a small shifter onto a result bus (the C bus). A write mask then stores that value into any set of registers, H included, on the next rising clock edge. All control arrives as plain inputs on every cycle, the way a microinstruction word would supply it. Nothing between two edges is stored: source selection, ALU and shifter are purely combinational.

The left ALU operand can be switched to zero, so an add turns into a pass-through of the B bus, or into B + 1 when the increment bit is set. This is how H is loaded and how a register is stepped in a single cycle. The registers that model the memory interface are plain storage here.

Top module: `twin_bus_datapath`

## Requirements
- R1: After reset every general register (indices 0 to 8) and H hold zero.
- R2: With the left enable low, function code 2'b11 (add) and increment low, the C bus equals the selected B-bus register.
- R3: The increment bit adds one only to the add function (2'b11), acting as its carry-in. With the left enable low the result is B + 1.
- R4: Function codes select 2'b00 = A AND B, 2'b01 = A OR B, 2'b10 = NOT B, 2'b11 = A + B. A is H when the left enable is high and zero otherwise, and it is bit-inverted when the invert control is high.
- R5: With the byte-shift control high, the C bus is the ALU result shifted left by 8 bits with the low 8 bits zero.
- R6: With only the one-bit shift control high, the C bus is the ALU result shifted right by one bit with bit 31 kept.
- R7: With neither shift control high, the C bus equals the ALU result. With both high, the byte-left shift is applied.
- R8: A register may be both the B-bus source and a write destination in one cycle, and it then stores the value computed from its old contents.
- R9: Write-mask bit k (k = 0 to 8) loads general register k and bit 9 loads H. Every set bit loads the same C-bus value on the same edge.
- R10: B-select codes 0 to 8 drive general register 0 to 8 onto the B bus. Codes 9 to 15 drive zero.
- R11: The negative flag is bit 31 of the ALU result and the zero flag is high when the ALU result is all zeros. Both are taken before the shifter.
- R12: A register whose mask bit is low keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers load on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| aluFn | input | 2 | ALU function code |
| leftEn | input | 1 | Left operand enable (low forces zero) |
| leftInv | input | 1 | Invert the left operand |
| incr | input | 1 | Carry-in for the add function |
| shl8 | input | 1 | Shift result left by one byte |
| sra1 | input | 1 | Shift result right by one bit, arithmetic |
| bSel | input | 4 | B-bus source select |
| cMask | input | 10 | Write mask: bits 0 to 8 general registers, bit 9 H |
| cBus | output | 32 | Shifter output, value written on the edge |
| negFlag | output | 1 | ALU result bit 31 |
| zeroFlag | output | 1 | ALU result is zero |

## Verification
On every cycle the assertions check that a masked register captures the C bus and an unmasked one stays put. They also check the pass-through and increment forms of the add, the zero fill of the byte shift, the kept sign bit of the one-bit shift, and that at most one register drives the B bus. Building values from an all-zero reset, reading a register while rewriting it, fanning one result into several registers, and the flags differing from the C bus after a shift can only be shown by the bench's sequences. The bench shows them by reading each register back through a pass-through add and comparing with its model.

// File: rtl/busdp_pkg.sv
package busdp_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_GP = 9;
  localparam int SEL_W = 4;
  localparam int MASK_W = NUM_GP + 1;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } aluFn_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_LEFT8  = 2'b01,
    SH_RIGHT1 = 2'b10
  } shift_e;

  typedef struct packed {
    aluFn_e             fn;
    logic               useA;
    logic               invA;
    logic               carryIn;
    shift_e             shift;
    logic [NUM_GP-1:0]  srcHot;
    logic [NUM_GP-1:0]  gpWrite;
    logic               hWrite;
  } strobe_t;
endpackage

// File: rtl/busdp_ctrl.sv
module busdp_ctrl
  import busdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fnSel,
  input  logic              leftEn,
  input  logic              leftInv,
  input  logic              incr,
  input  logic              shl8,
  input  logic              sra1,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [MASK_W-1:0] writeMask,
  output strobe_t           strobes
);
  logic [NUM_GP-1:0] srcHot;

  // One decoder line per general register; codes past the bank stay dark.
  for (genvar g = 0; g < NUM_GP; g++) begin : g_srcDec
    assign srcHot[g] = (srcSel == SEL_W'(g));
  end

  always_comb begin
    strobes.fn      = aluFn_e'(fnSel);
    strobes.useA    = leftEn;
    strobes.invA    = leftInv;
    strobes.carryIn = incr;
    if (shl8)      strobes.shift = SH_LEFT8;
    else if (sra1) strobes.shift = SH_RIGHT1;
    else           strobes.shift = SH_NONE;
    strobes.srcHot  = srcHot;
    strobes.gpWrite = writeMask[NUM_GP-1:0];
    strobes.hWrite  = writeMask[NUM_GP];
  end

  assert_src_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.srcHot));

  assert_shift_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    shl8 |-> strobes.shift == SH_LEFT8);
endmodule

// File: rtl/busdp_alu.sv
module busdp_alu
  import busdp_pkg::*;
(
  input  logic [WORD_W-1:0] hVal,
  input  logic [WORD_W-1:0] bVal,
  input  aluFn_e            fn,
  input  logic              useA,
  input  logic              invA,
  input  logic              carryIn,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] aGated;
  logic [WORD_W-1:0] aOp;

  always_comb begin
    aGated = useA ? hVal : '0;
    aOp    = invA ? ~aGated : aGated;
    unique case (fn)
      FN_AND:  result = aOp & bVal;
      FN_OR:   result = aOp | bVal;
      FN_NOTB: result = ~bVal;
      default: result = aOp + bVal + WORD_W'(carryIn);
    endcase
  end
endmodule

// File: rtl/busdp_path.sv
module busdp_path
  import busdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  output logic [WORD_W-1:0] cBus,
  output logic              negFlag,
  output logic              zeroFlag
);
  logic [WORD_W-1:0] gpReg [NUM_GP];
  logic [WORD_W-1:0] hReg;
  logic [WORD_W-1:0] bBus;
  logic [WORD_W-1:0] aluOut;

  // B bus: OR of the one selected register; no select means zero.
  always_comb begin
    bBus = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (strobes.srcHot[i]) bBus = bBus | gpReg[i];
  end

  busdp_alu u_alu (
    .hVal    (hReg),
    .bVal    (bBus),
    .fn      (strobes.fn),
    .useA    (strobes.useA),
    .invA    (strobes.invA),
    .carryIn (strobes.carryIn),
    .result  (aluOut)
  );

  always_comb begin
    unique case (strobes.shift)
      SH_LEFT8:  cBus = {aluOut[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      SH_RIGHT1: cBus = {aluOut[WORD_W-1], aluOut[WORD_W-1:1]};
      default:   cBus = aluOut;
    endcase
  end

  assign negFlag  = aluOut[WORD_W-1];
  assign zeroFlag = (aluOut == '0);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (!rstN)                   gpReg[g] <= '0;
      else if (strobes.gpWrite[g]) gpReg[g] <= cBus;
    end

    assert_gp_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobes.gpWrite[g] |=> gpReg[g] == $past(cBus));

    assert_gp_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.gpWrite[g] |=> $stable(gpReg[g]));
  end

  always_ff @(posedge clk) begin
    if (!rstN)               hReg <= '0;
    else if (strobes.hWrite) hReg <= cBus;
  end

  assert_h_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hWrite |=> hReg == $past(cBus));

  assert_h_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.hWrite |=> $stable(hReg));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.useA && strobes.fn == FN_ADD && !strobes.carryIn) |-> aluOut == bBus);

  assert_increment_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.useA && strobes.fn == FN_ADD && strobes.carryIn) |-> aluOut == bBus + 1);

  assert_byte_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift == SH_LEFT8 |-> cBus[BYTE_W-1:0] == '0);

  assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift == SH_RIGHT1 |-> cBus[WORD_W-1] == cBus[WORD_W-2]);

  assert_flag_unshifted_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift == SH_NONE |-> negFlag == cBus[WORD_W-1] && zeroFlag == (cBus == '0));
endmodule

// File: rtl/twin_bus_datapath.sv
module twin_bus_datapath
  import busdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        aluFn,
  input  logic              leftEn,
  input  logic              leftInv,
  input  logic              incr,
  input  logic              shl8,
  input  logic              sra1,
  input  logic [SEL_W-1:0]  bSel,
  input  logic [MASK_W-1:0] cMask,
  output logic [WORD_W-1:0] cBus,
  output logic              negFlag,
  output logic              zeroFlag
);
  strobe_t strobes;

  busdp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fnSel     (aluFn),
    .leftEn    (leftEn),
    .leftInv   (leftInv),
    .incr      (incr),
    .shl8      (shl8),
    .sra1      (sra1),
    .srcSel    (bSel),
    .writeMask (cMask),
    .strobes   (strobes)
  );

  busdp_path u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cBus     (cBus),
    .negFlag  (negFlag),
    .zeroFlag (zeroFlag)
  );
endmodule

// File: tb/twin_bus_datapath_tb.sv
module twin_bus_datapath_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  aluFn = 2'b11;
  logic        leftEn = 1'b0, leftInv = 1'b0, incr = 1'b0, shl8 = 1'b0, sra1 = 1'b0;
  logic [3:0]  bSel = 4'd0;
  logic [9:0]  cMask = '0;
  logic [31:0] cBus;
  logic        negFlag, zeroFlag;

  int checkCnt = 0, failCnt = 0;
  bit done = 1'b0;
  logic [31:0] mReg [10];

  always #4 clk = ~clk;

  twin_bus_datapath u_dut (
    .clk(clk), .rstN(rstN), .aluFn(aluFn), .leftEn(leftEn), .leftInv(leftInv),
    .incr(incr), .shl8(shl8), .sra1(sra1), .bSel(bSel), .cMask(cMask),
    .cBus(cBus), .negFlag(negFlag), .zeroFlag(zeroFlag)
  );

  task automatic doReset();
    rstN = 1'b0;
    cMask = '0;
    for (int k = 0; k < 10; k++) mReg[k] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge, update the model on it.
  task automatic step(input logic [3:0] sel, input logic [9:0] mask, input logic [1:0] fn,
                      input logic ea, input logic ia, input logic inc,
                      input logic sl, input logic sr, input string tag);
    logic [31:0] a, b, alu, sh;
    bSel = sel; cMask = mask; aluFn = fn; leftEn = ea; leftInv = ia;
    incr = inc; shl8 = sl; sra1 = sr;
    #1;
    a = ea ? mReg[9] : 32'd0;
    if (ia) a = ~a;
    b = (sel < 9) ? mReg[sel] : 32'd0;
    case (fn)
      2'b00:   alu = a & b;
      2'b01:   alu = a | b;
      2'b10:   alu = ~b;
      default: alu = a + b + {31'd0, inc};
    endcase
    if (sl)      sh = alu << 8;
    else if (sr) sh = $signed(alu) >>> 1;
    else         sh = alu;
    checkCnt++;
    if (cBus !== sh || negFlag !== alu[31] || zeroFlag !== (alu == 0)) begin
      failCnt++;
      $display("FAIL %s: cBus=%h neg=%b zero=%b expected cBus=%h neg=%b zero=%b",
               tag, cBus, negFlag, zeroFlag, sh, alu[31], alu == 0);
    end
    @(posedge clk);
    for (int k = 0; k < 10; k++) if (mask[k]) mReg[k] = sh;
    @(negedge clk);
  endtask

  task automatic readGp(input logic [3:0] sel, input string tag);
    step(sel, 10'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic readH(input string tag);
    step(4'd9, 10'd0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic readAll(input string tag);
    for (int k = 0; k < 9; k++) readGp(4'(k), tag);
    readH(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    readAll("R1");
    for (int s = 9; s < 16; s++) readGp(4'(s), "R10");

    // NOT B of zero gives all ones in r0
    step(4'd0, 10'b0000000001, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    // increment r1 in place three times
    for (int i = 0; i < 3; i++)
      step(4'd1, 10'b0000000010, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    readGp(4'd1, "R3");
    // increment does nothing for the logic functions
    step(4'd1, 10'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(4'd1, 10'd0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    // byte shifts build 0x03000000 in r2
    step(4'd1, 10'b0000000100, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    step(4'd2, 10'b0000000100, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    step(4'd2, 10'b0000000100, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    // flags before the shifter: ALU nonzero, C bus zero
    step(4'd2, 10'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
    // load H by pass-through
    step(4'd2, 10'b1000000000, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    readH("R2");
    // logic and arithmetic with H on the left
    step(4'd0, 10'b0000001000, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    step(4'd1, 10'b0000001000, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    step(4'd1, 10'b0000010000, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    step(4'd1, 10'b0000100000, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(4'd0, 10'd0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    // arithmetic right shifts, negative and positive
    step(4'd5, 10'b0001000000, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    step(4'd2, 10'b0010000000, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    step(4'd0, 10'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    // both shifts: byte-left wins
    step(4'd1, 10'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
    step(4'd5, 10'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
    // all-ones plus one wraps to zero
    step(4'd0, 10'd0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
    readAll("R12");
    // one result into several registers
    step(4'd1, 10'b1111000001, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    readAll("R9");
    // unused select writes zero
    step(4'd12, 10'b0000010010, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    // mask zero changes nothing
    step(4'd3, 10'd0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R12");
    readAll("R12");
    doReset();
    readAll("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule